// File: doc/BRIEF.md
# EEPROM Word Read Register

This block gives software a one-register way to fetch a single 16-bit word from an EEPROM. Software writes a 32-bit control/status register with the start bit set and a word address in the address field. The block latches the address and raises a request toward a word-wide EEPROM port. When that port acknowledges, the block stores the returned word in the upper half of the same register and sets a done flag. Software polls the register until done is set and then takes the data from bits 31:16.

Two register layouts are supported, chosen by the `LAYOUT` parameter. They differ in where the address field starts and where the done flag sits. The serial EEPROM engine is outside this block. It is seen only as a request/acknowledge word port: the request is held until acknowledge, and the data is valid in the acknowledge cycle.

Top module: `romword_reg_port`

## Requirements
- R1: After reset the register reads all zeros and `rom_req` is low.
- R2: A register write with bit 0 (start) set, accepted while idle, raises `rom_req` in the next cycle with `rom_addr` equal to the address field of that write. In the same cycle the done flag and bits 31:16 read as zero.
- R3: While `rom_ack` is low, `rom_req` stays high and `rom_addr` does not change.
- R4: A cycle with `rom_req` and `rom_ack` both high makes the register read `rom_data` in bits 31:16 with the done flag set, and drops `rom_req`, all from the next cycle on.
- R5: Once set, the done flag and the data field keep their values until the next accepted start. Writes with bit 0 clear have no effect at all.
- R6: A start written while a read is outstanding is ignored. The address is unchanged and no second request follows the acknowledge.
- R7: Bit 0 always reads as zero. Bits that belong to no field read as zero. The address field reads back the last accepted address.
- R8: With `LAYOUT`=0 the address field occupies bits starting at 8 (8 bits by default) and done is bit 4.
- R9: With `LAYOUT`=1 the address field occupies bits starting at 2 (up to 14 bits) and done is bit 1.
- R10: An acknowledge in the first cycle of a request completes the read, with the same result as a delayed acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read value |
| rom_req | output | 1 | Word read request, held until acknowledge |
| rom_addr | output | ADDR_W | Word address of the outstanding read |
| rom_ack | input | 1 | Acknowledge from the EEPROM port; data is valid in this cycle |
| rom_data | input | 16 | Word returned by the EEPROM port |

## Verification
A single read is run with a delayed acknowledge and again with an acknowledge in the first request cycle. Comparing the two shows whether completion depends on wait time. A start followed by a second start during the outstanding read, with a different address, shows whether mid-flight starts are dropped. Writes with the start bit clear, followed by idle cycles, show whether done and data stay held. A second instance built with the other layout receives a wide address, which shows whether the field offset and done position follow the parameter.

// File: rtl/romword_pkg.sv
// Package: shared types and layout helpers for the EEPROM word read register.
// Assumes LAYOUT is 0 or 1; any other value is treated as layout 1.
package romword_pkg;

    typedef enum logic {
        RW_IDLE = 1'b0,
        RW_WAIT = 1'b1
    } rw_state_t;

    localparam int START_POS = 0;
    localparam int DATA_LSB  = 16;
    localparam int DATA_W    = 16;

    // Lowest bit of the address field for a layout.
    function automatic int addr_lsb(input int layout);
        return (layout == 0) ? 8 : 2;
    endfunction

    // Position of the done flag for a layout.
    function automatic int done_pos(input int layout);
        return (layout == 0) ? 4 : 1;
    endfunction

endpackage

// File: rtl/romword_field_map.sv
// Module: splits a register write into start and address, and packs the
// register read value from the stored state.
// Assumes ADDR_W fits between the address LSB and bit 15 for the layout.
module romword_field_map
    import romword_pkg::*;
#(
    parameter int LAYOUT = 0,
    parameter int ADDR_W = 8
) (
    input  logic [31:0]       wdata,
    input  logic              st_done,
    input  logic [DATA_W-1:0] st_data,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              wr_start,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       rdata
);
    localparam int A_LSB = addr_lsb(LAYOUT);
    localparam int D_POS = done_pos(LAYOUT);

    logic unused_wbits;
    assign unused_wbits = ^wdata;

    // Pull the start bit and the address field out of a write.
    always_comb begin
        wr_start = wdata[START_POS];
        wr_addr  = wdata[A_LSB +: ADDR_W];
    end

    // Build the read value; start and unassigned bits read as zero.
    always_comb begin
        rdata                        = '0;
        rdata[DATA_LSB +: DATA_W]    = st_data;
        rdata[D_POS]                 = st_done;
        rdata[A_LSB +: ADDR_W]       = st_addr;
    end

endmodule

// File: rtl/romword_read_ctrl.sv
// Module: sequencer that issues one word read per accepted start.
// It holds the request until acknowledge, captures the data and sets done.
// Assumes the EEPROM port drives data valid in the acknowledge cycle.
module romword_read_ctrl
    import romword_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic              rom_ack,
    input  logic [DATA_W-1:0] rom_data,
    output logic              rom_req,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              accept
);
    rw_state_t         state;
    logic [ADDR_W-1:0] addr_q;

    // A start counts only when no read is outstanding.
    assign accept   = go && (state == RW_IDLE);
    assign rom_req  = (state == RW_WAIT);
    assign rom_addr = addr_q;

    // Advance the read sequence and capture address, data and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RW_IDLE;
            addr_q <= '0;
            done   <= 1'b0;
            data   <= '0;
        end else begin
            case (state)
                RW_IDLE: if (go) begin
                    state  <= RW_WAIT;
                    addr_q <= go_addr;
                    done   <= 1'b0;
                    data   <= '0;
                end
                RW_WAIT: if (rom_ack) begin
                    state <= RW_IDLE;
                    done  <= 1'b1;
                    data  <= rom_data;
                end
                default: state <= RW_IDLE;
            endcase
        end
    end

    // R2
    start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rom_req && !done && (data == '0));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req && !rom_ack |=> rom_req && $stable(rom_addr));

    // R4
    ack_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req && rom_ack |=> done && !rom_req && (data == $past(rom_data)));

    // R5
    done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !accept |=> done && $stable(data));

    // R6
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req && go |=> $stable(rom_addr));

endmodule

// File: rtl/romword_reg_port.sv
// Module: top of the EEPROM word read register. One 32-bit register carries
// start (bit 0), a word address, a done flag and the 16-bit result.
// Assumes a write strobe of one cycle per write; reads are combinational.
module romword_reg_port
    import romword_pkg::*;
#(
    parameter int LAYOUT = 0,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic              rom_req,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic              rom_ack,
    input  logic [15:0]       rom_data
);
    logic              wr_start;
    logic [ADDR_W-1:0] wr_addr;
    logic              st_done;
    logic [DATA_W-1:0] st_data;
    logic              accept;
    logic              go;

    // A start is a write carrying bit 0 set.
    assign go = csr_wr && wr_start;

    romword_field_map #(.LAYOUT(LAYOUT), .ADDR_W(ADDR_W)) i_map (
        .wdata    (csr_wdata),
        .st_done  (st_done),
        .st_data  (st_data),
        .st_addr  (rom_addr),
        .wr_start (wr_start),
        .wr_addr  (wr_addr),
        .rdata    (csr_rdata)
    );

    romword_read_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_addr  (wr_addr),
        .rom_ack  (rom_ack),
        .rom_data (rom_data),
        .rom_req  (rom_req),
        .rom_addr (rom_addr),
        .done     (st_done),
        .data     (st_data),
        .accept   (accept)
    );

    // R7
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[START_POS] == 1'b0);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !rom_req && (csr_rdata == 32'h0));

endmodule

// File: tb/test_romword_reg_port.sv
module test_romword_reg_port;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;

    logic        a_wr = 1'b0;
    logic [31:0] a_wdata = '0;
    logic [31:0] a_rdata;
    logic        a_req;
    logic [7:0]  a_addr;
    logic        a_ack = 1'b0;
    logic [15:0] a_rom = '0;

    logic        b_wr = 1'b0;
    logic [31:0] b_wdata = '0;
    logic [31:0] b_rdata;
    logic        b_req;
    logic [13:0] b_addr;
    logic        b_ack = 1'b0;
    logic [15:0] b_rom = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    romword_reg_port #(.LAYOUT(0), .ADDR_W(8)) i_romword_reg_port (
        .clk(clk), .rst_n(rst_n), .csr_wr(a_wr), .csr_wdata(a_wdata),
        .csr_rdata(a_rdata), .rom_req(a_req), .rom_addr(a_addr),
        .rom_ack(a_ack), .rom_data(a_rom)
    );

    romword_reg_port #(.LAYOUT(1), .ADDR_W(14)) i_romword_reg_port_alt (
        .clk(clk), .rst_n(rst_n), .csr_wr(b_wr), .csr_wdata(b_wdata),
        .csr_rdata(b_rdata), .rom_req(b_req), .rom_addr(b_addr),
        .rom_ack(b_ack), .rom_data(b_rom)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One-cycle register write on instance A; returns at the next negedge.
    task automatic wr_a(input logic [31:0] v);
        @(negedge clk); a_wr = 1'b1; a_wdata = v;
        @(negedge clk); a_wr = 1'b0; a_wdata = '0;
    endtask

    // One-cycle acknowledge on instance A; returns at the next negedge.
    task automatic ack_a(input logic [15:0] d);
        a_ack = 1'b1; a_rom = d;
        @(negedge clk); a_ack = 1'b0; a_rom = '0;
    endtask

    task automatic t_reset;
        chk("R1 rdata", a_rdata, 32'h0);
        chk("R1 req", {31'b0, a_req}, 32'h0);
    endtask

    task automatic t_basic;
        wr_a(32'h0000_5A01);
        chk("R2 req", {31'b0, a_req}, 32'h1);
        chk("R2 addr", {24'b0, a_addr}, 32'h5A);
        chk("R7 rdata", a_rdata, 32'h0000_5A00);
        repeat (3) @(negedge clk);
        chk("R3 req held", {31'b0, a_req}, 32'h1);
        chk("R3 addr held", {24'b0, a_addr}, 32'h5A);
        ack_a(16'hBEEF);
        chk("R4 req dropped", {31'b0, a_req}, 32'h0);
        chk("R8 R4 rdata", a_rdata, 32'hBEEF_5A10);
        wr_a(32'hFFFF_FFFE);
        chk("R5 no-start write", a_rdata, 32'hBEEF_5A10);
        chk("R5 no req", {31'b0, a_req}, 32'h0);
        repeat (5) @(negedge clk);
        chk("R5 held", a_rdata, 32'hBEEF_5A10);
    endtask

    task automatic t_restart;
        wr_a(32'h0000_0301);
        chk("R2 cleared", a_rdata, 32'h0000_0300);
        wr_a(32'h0000_7701);
        chk("R6 addr kept", {24'b0, a_addr}, 32'h03);
        chk("R6 req", {31'b0, a_req}, 32'h1);
        ack_a(16'h1234);
        chk("R6 result", a_rdata, 32'h1234_0310);
        @(negedge clk);
        chk("R6 no second req", {31'b0, a_req}, 32'h0);
    endtask

    task automatic t_zero_wait;
        wr_a(32'h0000_FF01);
        ack_a(16'h8001);
        chk("R10 rdata", a_rdata, 32'h8001_FF10);
        chk("R10 req", {31'b0, a_req}, 32'h0);
    endtask

    task automatic t_layout_b;
        chk("R9 reset", b_rdata, 32'h0);
        @(negedge clk); b_wr = 1'b1; b_wdata = 32'h0000_AAF1;
        @(negedge clk); b_wr = 1'b0; b_wdata = '0;
        chk("R9 addr", {18'b0, b_addr}, 32'h2ABC);
        chk("R9 pending", b_rdata, 32'h0000_AAF0);
        b_ack = 1'b1; b_rom = 16'hC0DE;
        @(negedge clk); b_ack = 1'b0; b_rom = '0;
        chk("R9 rdata", b_rdata, 32'hC0DE_AAF2);
        chk("R9 req", {31'b0, b_req}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_restart();
        t_zero_wait();
        t_layout_b();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles >= WATCHDOG) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

endmodule